// File: doc/BRIEF.md
# Three-State Pin Boundary-Scan Segment

This block is the boundary-scan slice for a single bidirectional, three-state I/O pin. It places three scan cells between the core and the pad. The first is an enable cell with no pin of its own, which decides whether the pad driver is on. The second is a data cell that supplies the driven level. The third is a receive cell that watches the pad. The three cells form one serial path. A test controller drives the path with single-cycle capture, shift and update strobes on the test clock. Two mode selects then decide who controls the pad and the core-side input.

With both selects low, the segment is transparent. The core's enable and data reach the pad unchanged, and the pad level returns to the core. Scan traffic in this mode leaves the pin alone. The external-test select hands the pad driver to the update stages of the enable and data cells. This lets a board test drive 0, 1 or high impedance from scanned values. The internal-test select feeds the receive cell's update stage to the core in place of the pad.

Top module: `bscan_pin_seg`

## Requirements
- R1: With ext_test_i and int_test_i low, pad_oe_o equals core_oe_i, pad_do_o equals core_do_i and core_di_o equals pad_di_i in the same cycle.
- R2: A clock edge with capture_i high loads the enable cell from core_oe_i, the data cell from core_do_i and the receive cell from pad_di_i. Afterwards tdo_o shows the receive cell.
- R3: A clock edge with shift_i high (capture_i low) moves the path one place: tdi_i enters the enable cell, the enable cell moves to the data cell, the data cell moves to the receive cell, and tdo_o always shows the receive cell. A bit shifted in therefore reaches tdo_o after exactly three shift edges.
- R4: When capture_i and shift_i are both high on an edge, the capture takes effect and no shift happens.
- R5: The update stages load from the shift stages only on an edge with update_i high. Otherwise they hold. Shifting or capturing without an update never changes pad_do_o, pad_oe_o or core_di_o in any mode.
- R6: Reset (rst_ni low) clears all update stages to 0. Under ext_test_i right after reset, the pad is therefore undriven (pad_oe_o = 0, pad_do_o = 0).
- R7: With ext_test_i high, pad_oe_o equals the enable cell's update stage and pad_do_o equals the data cell's update stage. An enable value of 0 gives high impedance, and 1 drives the data value. All three pad states can be reached.
- R8: With int_test_i high, core_di_o equals the receive cell's update stage and no longer follows pad_di_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output (receive cell shift stage) |
| capture_i | input | 1 | Parallel capture strobe |
| shift_i | input | 1 | Serial shift strobe |
| update_i | input | 1 | Update strobe |
| ext_test_i | input | 1 | Pad driven from update stages |
| int_test_i | input | 1 | Core input driven from receive cell update stage |
| core_oe_i | input | 1 | Core output enable |
| core_do_i | input | 1 | Core output data |
| core_di_o | output | 1 | Input value returned to the core |
| pad_do_o | output | 1 | Pad driver data |
| pad_oe_o | output | 1 | Pad driver enable |
| pad_di_i | input | 1 | Pad receiver value |

## Verification
Random core and pad values in normal mode, with scan strobes mixed in, show whether the pin stays transparent and undisturbed by scan traffic. Captures from random parallel values, followed by three shifts, show whether each cell sits in the right place on the path. A fresh pattern shifted in behind them shows whether the path order is reversed. Random three-bit patterns that are updated under external and internal test cover all three pad states and the core-side substitute. Directed cases cover capture winning over shift, shifting without update, and the undriven pad after reset.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int unsigned CELL_EN   = 0;
  localparam int unsigned CELL_DATA = 1;
  localparam int unsigned CELL_RX   = 2;
  localparam int unsigned N_CELLS   = 3;

  typedef logic [N_CELLS-1:0] cell_vec_t;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter bit UPD_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic test_sel_i,
  input  logic pi_i,
  input  logic si_i,
  output logic so_o,
  output logic upd_o,
  output logic po_o
);
  logic sh_q, up_q;

  // capture wins over shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= 1'b0;
    else if (capture_i) sh_q <= pi_i;
    else if (shift_i)   sh_q <= si_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       up_q <= UPD_RST;
    else if (update_i) up_q <= sh_q;
  end

  assign so_o  = sh_q;
  assign upd_o = up_q;
  assign po_o  = test_sel_i ? up_q : pi_i;
endmodule

// File: rtl/bscan_pin_seg.sv
module bscan_pin_seg
  import bscan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tdi_i,
  output logic tdo_o,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic ext_test_i,
  input  logic int_test_i,
  input  logic core_oe_i,
  input  logic core_do_i,
  output logic core_di_o,
  output logic pad_do_o,
  output logic pad_oe_o,
  input  logic pad_di_i
);
  cell_vec_t pi_v, si_v, sel_v, sh_v, up_v, po_v;

  assign pi_v[CELL_EN]   = core_oe_i;
  assign pi_v[CELL_DATA] = core_do_i;
  assign pi_v[CELL_RX]   = pad_di_i;

  assign sel_v[CELL_EN]   = ext_test_i;
  assign sel_v[CELL_DATA] = ext_test_i;
  assign sel_v[CELL_RX]   = int_test_i;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign si_v[i] = tdi_i;
    end else begin : g_link
      assign si_v[i] = sh_v[i-1];
    end
    bscan_cell #(.UPD_RST(1'b0)) i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture_i),
      .shift_i   (shift_i),
      .update_i  (update_i),
      .test_sel_i(sel_v[i]),
      .pi_i      (pi_v[i]),
      .si_i      (si_v[i]),
      .so_o      (sh_v[i]),
      .upd_o     (up_v[i]),
      .po_o      (po_v[i])
    );
  end

  assign tdo_o     = sh_v[N_CELLS-1];
  assign pad_oe_o  = po_v[CELL_EN];
  assign pad_do_o  = po_v[CELL_DATA];
  assign core_di_o = po_v[CELL_RX];
endmodule

// File: rtl/bscan_pin_seg_chk.sv
module bscan_pin_seg_chk
  import bscan_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tdi_i,
  input logic      tdo_o,
  input logic      capture_i,
  input logic      shift_i,
  input logic      update_i,
  input logic      ext_test_i,
  input logic      int_test_i,
  input logic      core_oe_i,
  input logic      core_do_i,
  input logic      core_di_o,
  input logic      pad_do_o,
  input logic      pad_oe_o,
  input logic      pad_di_i,
  input cell_vec_t sh_v,
  input cell_vec_t up_v
);
  assert_transparent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_test_i && !int_test_i) |->
      (pad_oe_o == core_oe_i && pad_do_o == core_do_i && core_di_o == pad_di_i));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (sh_v[CELL_EN] == $past(core_oe_i) && sh_v[CELL_DATA] == $past(core_do_i)
                   && tdo_o == $past(pad_di_i)));

  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sh_v[CELL_EN] == $past(tdi_i) &&
      sh_v[CELL_DATA] == $past(sh_v[CELL_EN]) && tdo_o == $past(sh_v[CELL_DATA])));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(up_v));

  assert_reset_R6: assert property (@(posedge clk_i) !rst_ni |-> up_v == '0);

  assert_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_test_i |-> (pad_oe_o == up_v[CELL_EN] && pad_do_o == up_v[CELL_DATA]));

  assert_int_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_test_i |-> core_di_o == up_v[CELL_RX]);
endmodule

bind bscan_pin_seg bscan_pin_seg_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tdi_i     (tdi_i),
  .tdo_o     (tdo_o),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .ext_test_i(ext_test_i),
  .int_test_i(int_test_i),
  .core_oe_i (core_oe_i),
  .core_do_i (core_do_i),
  .core_di_o (core_di_o),
  .pad_do_o  (pad_do_o),
  .pad_oe_o  (pad_oe_o),
  .pad_di_i  (pad_di_i),
  .sh_v      (sh_v),
  .up_v      (up_v)
);

// File: tb/test_bscan_pin_seg.sv
module test_bscan_pin_seg;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tdi_i = 0, capture_i = 0, shift_i = 0, update_i = 0;
  logic ext_test_i = 0, int_test_i = 0, core_oe_i = 0, core_do_i = 0, pad_di_i = 0;
  logic tdo_o, core_di_o, pad_do_o, pad_oe_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  bscan_pin_seg i_bscan_pin_seg (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one strobe cycle; called and returns at negedge
  task automatic cyc(input logic c, input logic s, input logic u, input logic d);
    capture_i = c; shift_i = s; update_i = u; tdi_i = d;
    @(negedge clk_i);
    capture_i = 0; shift_i = 0; update_i = 0;
  endtask

  // load en/data/rx then update; rx goes in first
  task automatic load(input logic en, input logic dat, input logic rx);
    cyc(0, 1, 0, rx); cyc(0, 1, 0, dat); cyc(0, 1, 0, en); cyc(0, 0, 1, 0);
  endtask

  function automatic logic exp_oe(input logic ext, input logic upd_en, input logic coe);
    return ext ? upd_en : coe;
  endfunction

  function automatic logic exp_di(input logic it, input logic upd_rx, input logic pad);
    return it ? upd_rx : pad;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1149));
    ext_test_i = 1;
    @(negedge clk_i);
    chk("R6 reset oe", pad_oe_o, 1'b0);
    chk("R6 reset do", pad_do_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R6 after reset oe", pad_oe_o, 1'b0);
    ext_test_i = 0;

    // R1/R5: normal mode transparency, undisturbed by scan strobes
    for (int i = 0; i < 40; i++) begin
      core_oe_i = 1'($urandom); core_do_i = 1'($urandom); pad_di_i = 1'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      chk("R1 oe", pad_oe_o, core_oe_i);
      chk("R1 do", pad_do_o, core_do_i);
      chk("R5 R1 di", core_di_o, pad_di_i);
    end

    // R2/R3: capture then read out in path order, then fresh bits follow
    for (int i = 0; i < 20; i++) begin
      logic a, b, c, n0, n1, n2;
      a = 1'($urandom); b = 1'($urandom); c = 1'($urandom);
      n0 = 1'($urandom); n1 = 1'($urandom); n2 = 1'($urandom);
      core_oe_i = a; core_do_i = b; pad_di_i = c;
      cyc(1, 0, 0, 0);
      chk("R2 rx on tdo", tdo_o, c);
      cyc(0, 1, 0, n0); chk("R3 data on tdo", tdo_o, b);
      cyc(0, 1, 0, n1); chk("R3 en on tdo", tdo_o, a);
      cyc(0, 1, 0, n2); chk("R3 first new bit after 3 shifts", tdo_o, n0);
      cyc(0, 1, 0, 0);  chk("R3 second new bit", tdo_o, n1);
    end

    // R4: capture beats shift
    core_oe_i = 0; core_do_i = 0; pad_di_i = 1;
    cyc(1, 1, 0, 0);
    chk("R4 capture priority", tdo_o, 1'b1);

    // R7/R8/R5: random patterns under external and internal test
    ext_test_i = 1; int_test_i = 1;
    for (int i = 0; i < 30; i++) begin
      logic en, dat, rx;
      en = 1'($urandom); dat = 1'($urandom); rx = 1'($urandom);
      core_oe_i = 1'($urandom); core_do_i = 1'($urandom); pad_di_i = 1'($urandom);
      load(en, dat, rx);
      chk("R7 oe", pad_oe_o, exp_oe(1'b1, en, core_oe_i));
      chk("R7 do", pad_do_o, dat);
      chk("R8 di", core_di_o, exp_di(1'b1, rx, pad_di_i));
      cyc(0, 1, 0, ~en); cyc(1, 0, 0, 0);
      chk("R5 oe held while scanning", pad_oe_o, en);
      chk("R5 do held while scanning", pad_do_o, dat);
      chk("R5 di held while scanning", core_di_o, rx);
    end

    // R7: three pad states directed
    load(0, 1, 0); chk("R7 high-z oe", pad_oe_o, 1'b0);
    load(1, 0, 0); chk("R7 drive 0 oe", pad_oe_o, 1'b1); chk("R7 drive 0 do", pad_do_o, 1'b0);
    load(1, 1, 1); chk("R7 drive 1 oe", pad_oe_o, 1'b1); chk("R7 drive 1 do", pad_do_o, 1'b1);
    pad_di_i = 0; #1;
    chk("R8 pad ignored", core_di_o, 1'b1);
    int_test_i = 0; #1;
    chk("R8 off follows pad", core_di_o, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule